// File: doc/BRIEF.md
# Add-On FIFO Direct-Strobe Port

This block is the add-on side of a bridge between a host bus and local add-on logic. It holds two FIFOs. The outbound FIFO carries data from the add-on to the host, and the inbound FIFO carries data from the host to the add-on. Add-on logic can reach the FIFO data in two ways. The first is a pair of dedicated active-low strobes that need no chip select and no address. The second is an ordinary register cycle that decodes a fixed FIFO address. This lets a simple external DMA engine stream data with one strobe per beat, while a processor on the same bus uses normal register cycles.

Two registered status outputs report the outbound full state and the inbound empty state. Both are active low in the sense that a low level asks for service, so each one can drive a DMA request line directly. A mode input selects a 32-bit or a 16-bit add-on data bus. In 16-bit mode, pairs of half-words are packed into full 32-bit entries, and 32-bit entries are split back into half-words. The host side is reduced to a simple push/pop test port.

Each clock cycle in which an access condition is present counts as exactly one access. A strobe held low for N cycles therefore makes N accesses.

Top module: `addon_fifo_port`

## Requirements
- R1: Each cycle with `wr_stb_n` low pushes `wdata` into the outbound FIFO in 32-bit mode (`half_mode`=0). Entries leave at `host_rdata` in push order.
- R2: During a cycle with `rd_stb_n` low and the inbound FIFO non-empty, `rdata` shows the oldest inbound entry, and that entry is removed at the end of the cycle (32-bit mode).
- R3: A register cycle reaches the same FIFOs. A write needs `sel_n`=0, `reg_addr`=5'b01000 and `reg_wr_n`=0. A read needs `sel_n`=0, `reg_addr`=5'b01000 and `reg_rd_n`=0. Any other `reg_addr` value has no effect on either FIFO.
- R4: With `half_mode`=1, two accepted writes are packed into one entry. The first `wdata[15:0]` becomes bits 15:0 and the second becomes bits 31:16. The entry is pushed on the second write.
- R5: With `half_mode`=1, an entry is read in two accesses. The first gives bits 15:0 and the second gives bits 31:16, each on `rdata[15:0]` with `rdata[31:16]`=0. The entry is removed on the second access.
- R6: `wr_full` is 0 while the outbound FIFO (8 entries) has space. It becomes 1 from the clock edge that stores the eighth entry, and it returns to 0 on the edge that frees a slot.
- R7: `rd_empty` is 0 while the inbound FIFO holds data. It becomes 1 from the clock edge that removes the last entry, and it becomes 0 on the edge that stores an entry.
- R8: A write while the outbound FIFO is full is ignored. The stored entries, their order and the flags are unchanged.
- R9: A read while the inbound FIFO is empty is ignored. `rdata` is 0 during that cycle, and the FIFO and half-word position are unchanged.
- R10: After synchronous reset, both FIFOs are empty, `wr_full`=0, `rd_empty`=1, `host_rvalid`=0 and `rdata`=0.
- R11: Cycles with both strobes high and no register access change neither FIFO nor either status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_mode | input | 1 | 0 = 32-bit add-on bus, 1 = 16-bit add-on bus |
| wr_stb_n | input | 1 | Direct outbound write strobe, active low, idles high |
| rd_stb_n | input | 1 | Direct inbound read strobe, active low, idles high |
| sel_n | input | 1 | Register chip select, active low |
| reg_addr | input | 5 | Register word address (byte address bits 6:2) |
| reg_wr_n | input | 1 | Register write enable, active low |
| reg_rd_n | input | 1 | Register read enable, active low |
| wdata | input | 32 | Add-on write data |
| rdata | output | 32 | Add-on read data, 0 when no read is accepted |
| wr_full | output | 1 | Outbound FIFO full; low acts as write DMA request |
| rd_empty | output | 1 | Inbound FIFO empty; low acts as read DMA request |
| host_push | input | 1 | Host test port: store `host_wdata` into the inbound FIFO |
| host_wdata | input | 32 | Host test port write data |
| host_in_full | output | 1 | Inbound FIFO full |
| host_pop | input | 1 | Host test port: remove the head of the outbound FIFO |
| host_rdata | output | 32 | Head of the outbound FIFO |
| host_rvalid | output | 1 | Outbound FIFO holds data |

## Verification
Some properties are checked by assertions on every cycle. These are: the flags never claim full and empty at once, a blocked push or pop leaves the entry count unchanged, idle cycles keep the count stable, and the half-word position advances only on an accepted access. Other behaviour can only be shown by the directed scenarios. These are: the data order through each FIFO, the packing and unpacking order of half-words, the exact edge on which each status output changes, the decoding of the register address against a neighbouring address, and the fact that data written after an overflow attempt does not displace stored entries.

// File: rtl/addon_fifo_pkg.sv
package addon_fifo_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int REG_ADDR_W = 5;
    localparam logic [REG_ADDR_W-1:0] FIFO_REG_ADDR = 5'b01000;

    typedef enum logic {
        BUS_WORD = 1'b0,
        BUS_HALF = 1'b1
    } bus_width_e;

    typedef struct packed {
        logic push;
        logic pop;
    } fifo_req_t;

    function automatic logic [WORD_W-1:0] join_halves(
        input logic [HALF_W-1:0] upper,
        input logic [HALF_W-1:0] lower
    );
        return {upper, lower};
    endfunction

    function automatic logic [HALF_W-1:0] pick_half(
        input logic [WORD_W-1:0] word,
        input logic              upper
    );
        return upper ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          full_q, empty_q;
    logic          do_push, do_pop;

    assign do_push = push && !full_q;
    assign do_pop  = pop && !empty_q;

    always_comb begin
        cnt_nxt = cnt;
        if (do_push && !do_pop) cnt_nxt = cnt + 1'b1;
        else if (do_pop && !do_push) cnt_nxt = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt     <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt     <= cnt_nxt;
            full_q  <= (cnt_nxt == FULL_CNT);
            empty_q <= (cnt_nxt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign full  = full_q;
    assign empty = empty_q;

    // R6 / R7: flags never contradict each other
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(full_q && empty_q));
    // R8: a push against a full FIFO stores nothing
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (full_q && push && !pop) |=> (cnt == $past(cnt)));
    // R9: a pop against an empty FIFO removes nothing
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        (empty_q && pop && !push) |=> (cnt == '0));
    // R11: idle cycles keep the occupancy
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/afp_access_decode.sv
module afp_access_decode
    import addon_fifo_pkg::*;
(
    input  logic                  wr_stb_n,
    input  logic                  rd_stb_n,
    input  logic                  sel_n,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr_n,
    input  logic                  reg_rd_n,
    output fifo_req_t             req
);
    logic hit;

    assign hit      = !sel_n && (reg_addr == FIFO_REG_ADDR);
    assign req.push = !wr_stb_n || (hit && !reg_wr_n);
    assign req.pop  = !rd_stb_n || (hit && !reg_rd_n);
endmodule

// File: rtl/afp_wr_pack.sv
module afp_wr_pack
    import addon_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_width_e        width,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wdata,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);
    logic [HALF_W-1:0] low_q;
    logic              upper_q;
    logic              accept;

    assign accept = wr_req && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst || width == BUS_WORD) begin
            upper_q <= 1'b0;
            low_q   <= '0;
        end else if (accept) begin
            if (!upper_q) low_q <= wdata[HALF_W-1:0];
            upper_q <= !upper_q;
        end
    end

    always_comb begin
        if (width == BUS_WORD) begin
            push      = wr_req;
            push_data = wdata;
        end else begin
            push      = wr_req && upper_q;
            push_data = join_halves(wdata[HALF_W-1:0], low_q);
        end
    end

    // R4: the half-word position moves only on an accepted write
    p_pack_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (width == BUS_HALF && !accept && $past(width) == BUS_HALF) |=> $stable(upper_q));
endmodule

// File: rtl/afp_rd_unpack.sv
module afp_rd_unpack
    import addon_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_width_e        width,
    input  logic              rd_req,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output logic [WORD_W-1:0] rdata
);
    logic upper_q;
    logic accept;

    assign accept = rd_req && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst || width == BUS_WORD) upper_q <= 1'b0;
        else if (accept)              upper_q <= !upper_q;
    end

    always_comb begin
        pop   = 1'b0;
        rdata = '0;
        if (width == BUS_WORD) begin
            pop = rd_req;
            if (accept) rdata = head;
        end else begin
            pop = rd_req && upper_q;
            if (accept) rdata = {{(WORD_W-HALF_W){1'b0}}, pick_half(head, upper_q)};
        end
    end

    // R5: after a first-half read the next access reads the upper half
    p_unpack_step_r5: assert property (@(posedge clk) disable iff (rst)
        (width == BUS_HALF && accept && !upper_q) |=> (upper_q || width == BUS_WORD));
    // R9: a read against an empty FIFO leaves the half position alone
    p_empty_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (width == BUS_HALF && fifo_empty && $past(width) == BUS_HALF) |=> $stable(upper_q));
endmodule

// File: rtl/addon_fifo_port.sv
module addon_fifo_port
    import addon_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  half_mode,
    input  logic                  wr_stb_n,
    input  logic                  rd_stb_n,
    input  logic                  sel_n,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr_n,
    input  logic                  reg_rd_n,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic                  wr_full,
    output logic                  rd_empty,
    input  logic                  host_push,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic                  host_in_full,
    input  logic                  host_pop,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  host_rvalid
);
    bus_width_e        width;
    fifo_req_t         req;
    logic              out_push, out_full, out_empty;
    logic [WORD_W-1:0] out_data;
    logic              in_pop, in_full, in_empty;
    logic [WORD_W-1:0] in_head;

    assign width = half_mode ? BUS_HALF : BUS_WORD;

    afp_access_decode u_decode (
        .wr_stb_n (wr_stb_n),
        .rd_stb_n (rd_stb_n),
        .sel_n    (sel_n),
        .reg_addr (reg_addr),
        .reg_wr_n (reg_wr_n),
        .reg_rd_n (reg_rd_n),
        .req      (req)
    );

    afp_wr_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .width     (width),
        .wr_req    (req.push),
        .wdata     (wdata),
        .fifo_full (out_full),
        .push      (out_push),
        .push_data (out_data)
    );

    afp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_out_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (out_push),
        .push_data (out_data),
        .pop       (host_pop),
        .head      (host_rdata),
        .full      (out_full),
        .empty     (out_empty)
    );

    afp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_in_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (host_push),
        .push_data (host_wdata),
        .pop       (in_pop),
        .head      (in_head),
        .full      (in_full),
        .empty     (in_empty)
    );

    afp_rd_unpack u_unpack (
        .clk        (clk),
        .rst        (rst),
        .width      (width),
        .rd_req     (req.pop),
        .fifo_empty (in_empty),
        .head       (in_head),
        .pop        (in_pop),
        .rdata      (rdata)
    );

    assign wr_full      = out_full;
    assign rd_empty     = in_empty;
    assign host_in_full = in_full;
    assign host_rvalid  = !out_empty;

    // R7: an idle inbound side keeps its request line
    p_rd_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!host_push && rd_stb_n && (sel_n || reg_rd_n)) |=> $stable(rd_empty));
    // R6: an idle outbound side keeps its request line
    p_wr_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!host_pop && wr_stb_n && (sel_n || reg_wr_n)) |=> $stable(wr_full));
endmodule

// File: tb/addon_fifo_port_tb.sv
module addon_fifo_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half_mode = 1'b0;
    logic        wr_stb_n = 1'b1, rd_stb_n = 1'b1;
    logic        sel_n = 1'b1, reg_wr_n = 1'b1, reg_rd_n = 1'b1;
    logic [4:0]  reg_addr = 5'd0;
    logic [31:0] wdata = '0, host_wdata = '0;
    logic        host_push = 1'b0, host_pop = 1'b0;
    logic [31:0] rdata, host_rdata;
    logic        wr_full, rd_empty, host_in_full, host_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addon_fifo_port dut_i (
        .clk(clk), .rst(rst), .half_mode(half_mode),
        .wr_stb_n(wr_stb_n), .rd_stb_n(rd_stb_n), .sel_n(sel_n),
        .reg_addr(reg_addr), .reg_wr_n(reg_wr_n), .reg_rd_n(reg_rd_n),
        .wdata(wdata), .rdata(rdata), .wr_full(wr_full), .rd_empty(rd_empty),
        .host_push(host_push), .host_wdata(host_wdata), .host_in_full(host_in_full),
        .host_pop(host_pop), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // each access: drive at negedge, sample mid-cycle, commit at posedge
    task automatic strobe_write(input logic [31:0] d);
        @(negedge clk); wdata = d; wr_stb_n = 1'b0;
        @(posedge clk); #1 wr_stb_n = 1'b1;
    endtask

    task automatic strobe_read(output logic [31:0] d);
        @(negedge clk); rd_stb_n = 1'b0; #2 d = rdata;
        @(posedge clk); #1 rd_stb_n = 1'b1;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); sel_n = 1'b0; reg_addr = a; reg_wr_n = 1'b0; wdata = d;
        @(posedge clk); #1 sel_n = 1'b1; reg_wr_n = 1'b1;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); sel_n = 1'b0; reg_addr = a; reg_rd_n = 1'b0; #2 d = rdata;
        @(posedge clk); #1 sel_n = 1'b1; reg_rd_n = 1'b1;
    endtask

    task automatic hpush(input logic [31:0] d);
        @(negedge clk); host_push = 1'b1; host_wdata = d;
        @(posedge clk); #1 host_push = 1'b0;
    endtask

    task automatic hpop(output logic [31:0] d);
        @(negedge clk); d = host_rdata; host_pop = 1'b1;
        @(posedge clk); #1 host_pop = 1'b0;
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    task automatic t_reset;
        settle();
        check("R10 wr_full", {31'b0, wr_full}, 32'd0);
        check("R10 rd_empty", {31'b0, rd_empty}, 32'd1);
        check("R10 host_rvalid", {31'b0, host_rvalid}, 32'd0);
        check("R10 rdata", rdata, 32'd0);
    endtask

    task automatic t_direct_write;
        logic [31:0] d;
        strobe_write(32'hDEAD_0001);
        strobe_write(32'hDEAD_0002);
        strobe_write(32'hDEAD_0003);
        for (int i = 1; i <= 3; i++) begin
            hpop(d);
            check("R1 order", d, 32'hDEAD_0000 + 32'(i));
        end
        settle();
        check("R1 drained", {31'b0, host_rvalid}, 32'd0);
    endtask

    task automatic t_direct_read;
        logic [31:0] d;
        hpush(32'h1234_5678);
        hpush(32'h9ABC_DEF0);
        settle();
        check("R7 rd_empty low with data", {31'b0, rd_empty}, 32'd0);
        strobe_read(d);
        check("R2 first", d, 32'h1234_5678);
        strobe_read(d);
        check("R2 second", d, 32'h9ABC_DEF0);
        settle();
        check("R7 rd_empty high after last", {31'b0, rd_empty}, 32'd1);
    endtask

    task automatic t_reg_access;
        logic [31:0] d;
        reg_write(5'b01001, 32'hBAD0_BAD0);
        settle();
        check("R3 other address ignored (write)", {31'b0, host_rvalid}, 32'd0);
        reg_write(5'b01000, 32'hC0DE_0008);
        hpop(d);
        check("R3 register write", d, 32'hC0DE_0008);
        hpush(32'h5A5A_A5A5);
        reg_read(5'b00111, d);
        check("R3 other address reads 0", d, 32'd0);
        settle();
        check("R3 other address ignored (read)", {31'b0, rd_empty}, 32'd0);
        reg_read(5'b01000, d);
        check("R3 register read", d, 32'h5A5A_A5A5);
        settle();
        check("R3 register read removed entry", {31'b0, rd_empty}, 32'd1);
    endtask

    task automatic t_fill;
        logic [31:0] d;
        for (int i = 0; i < 7; i++) strobe_write(32'hF000_0000 + 32'(i));
        settle();
        check("R6 not full at 7", {31'b0, wr_full}, 32'd0);
        strobe_write(32'hF000_0007);
        settle();
        check("R6 full at 8", {31'b0, wr_full}, 32'd1);
        strobe_write(32'hEEEE_EEEE);
        settle();
        check("R8 still full", {31'b0, wr_full}, 32'd1);
        hpop(d);
        check("R8 head kept", d, 32'hF000_0000);
        settle();
        check("R6 space after pop", {31'b0, wr_full}, 32'd0);
        for (int i = 1; i < 8; i++) begin
            hpop(d);
            check("R8 order kept", d, 32'hF000_0000 + 32'(i));
        end
        settle();
        check("R8 overflow word not stored", {31'b0, host_rvalid}, 32'd0);
    endtask

    task automatic t_empty_read;
        logic [31:0] d;
        strobe_read(d);
        check("R9 empty read gives 0", d, 32'd0);
        settle();
        check("R9 still empty", {31'b0, rd_empty}, 32'd1);
        hpush(32'h0BAD_F00D);
        strobe_read(d);
        check("R9 next read intact", d, 32'h0BAD_F00D);
    endtask

    task automatic t_half_write;
        logic [31:0] d;
        settle(); half_mode = 1'b1;
        strobe_write(32'hFFFF_1111);
        settle();
        check("R4 no push after one half", {31'b0, host_rvalid}, 32'd0);
        reg_write(5'b01000, 32'hFFFF_2222);
        hpop(d);
        check("R4 packed low first", d, 32'h2222_1111);
        settle(); half_mode = 1'b0;
    endtask

    task automatic t_half_read;
        logic [31:0] d;
        hpush(32'hAAAA_5555);
        settle(); half_mode = 1'b1;
        strobe_read(d);
        check("R5 low half", d, 32'h0000_5555);
        settle();
        check("R5 entry kept after first half", {31'b0, rd_empty}, 32'd0);
        strobe_read(d);
        check("R5 high half", d, 32'h0000_AAAA);
        settle();
        check("R5 removed after second half", {31'b0, rd_empty}, 32'd1);
        settle(); half_mode = 1'b0;
    endtask

    task automatic t_idle;
        logic [31:0] d;
        hpush(32'h7777_0001);
        repeat (4) settle();
        check("R11 rd_empty steady", {31'b0, rd_empty}, 32'd0);
        check("R11 wr_full steady", {31'b0, wr_full}, 32'd0);
        check("R11 outbound untouched", {31'b0, host_rvalid}, 32'd0);
        strobe_read(d);
        check("R11 data intact", d, 32'h7777_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_direct_write();
        t_direct_read();
        t_reg_access();
        t_fill();
        t_empty_read();
        t_half_write();
        t_half_read();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule